// File: doc/BRIEF.md
# Strided Masked Cache Address Translator

This unit turns a byte address and the configuration of one cache partition into a placement inside a direct-mapped cache. The partition is described by five fields: its first line, its size in physical lines, its size in physical lines per virtual line, a sub-word stride and an additive perturbation mask. The unit adds the mask to the address, shifts the sum right by the position of the stride's lowest set bit, and then splits the shifted value into a sub-word index, a line offset that wraps inside the partition, and a tag.

A lookup is presented with `in_valid` and its result appears on the outputs one clock later, together with `out_valid`. The physical line, the virtual line inside the partition and the tag feed the storage and hit logic that sit outside this block. The unmodified address travels alongside the result so that memory traffic uses the original address, not the perturbed one. All size fields are treated as powers of two: only their lowest set bit counts, and a zero field counts as one.

Top module: `part_xlate`

## Requirements
- R1: A lookup accepted with `in_valid` high produces its result, with `out_valid` high, exactly one clock later; a cycle with `in_valid` low produces `out_valid` low one clock later.
- R2: The placement address is `addr + mask` modulo 2^ADDR_W, and the shifted value is that sum shifted right by the bit position of the lowest set bit of `stride` (a zero stride gives a shift of 0).
- R3: `out_word` equals the shifted value modulo the words per line (2^WORD_W).
- R4: `out_line` equals `start` plus (shifted value / words per line) modulo the partition size, the sum taken modulo 2^LINE_W; the partition size is the lowest set bit of `psize` as a power of two, or 1 when `psize` is zero.
- R5: `out_vline` equals the line offset of R4 divided by the virtual size, taken as the lowest set bit of `vsize` (1 when zero).
- R6: `out_tag` equals the shifted value divided by (words per line times partition size), so it holds none of the offset or word bits.
- R7: `out_mem_addr` equals the incoming `addr`, unaffected by `mask` or `stride`.
- R8: While `in_valid` is low, all result outputs keep the value of the last accepted lookup.
- R9: While `rst_n` is low, on the next clock `out_valid` and every result output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Lookup present this cycle |
| addr | input | ADDR_W | Byte address of the access |
| start | input | LINE_W | First physical line of the partition |
| psize | input | LINE_W+1 | Physical lines in the partition (power of two) |
| vsize | input | LINE_W+1 | Physical lines per virtual line (power of two) |
| stride | input | STRIDE_W | Byte distance between sub-words (power of two) |
| mask | input | ADDR_W | Additive placement perturbation |
| out_valid | output | 1 | Result valid |
| out_line | output | LINE_W | Physical cache line |
| out_word | output | WORD_W | Sub-word inside the line |
| out_vline | output | LINE_W | Virtual line inside the partition |
| out_tag | output | ADDR_W | Tag to compare against stored lines |
| out_mem_addr | output | ADDR_W | Original address for memory access |

## Verification
Any fault in the shift, offset or tag path shows at the ports on the very next clock after a lookup, because the block has a single register stage and no other state. A wrong stride or size decode moves the line, the word and the tag together for most addresses, while a carry error in the mask sum appears only for addresses whose sum crosses a power-of-two boundary, which is why mask values are drawn across the full width. A fault in the holding register shows as an output that changes during a cycle with no lookup.

// File: rtl/part_xlate.sv
module part_xlate #(
  parameter int ADDR_W   = 32,
  parameter int LINE_W   = 7,
  parameter int WORD_W   = 2,
  parameter int STRIDE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [LINE_W-1:0]   start,
  input  logic [LINE_W:0]     psize,
  input  logic [LINE_W:0]     vsize,
  input  logic [STRIDE_W-1:0] stride,
  input  logic [ADDR_W-1:0]   mask,
  output logic                out_valid,
  output logic [LINE_W-1:0]   out_line,
  output logic [WORD_W-1:0]   out_word,
  output logic [LINE_W-1:0]   out_vline,
  output logic [ADDR_W-1:0]   out_tag,
  output logic [ADDR_W-1:0]   out_mem_addr
);

  localparam int SH_W = (STRIDE_W > LINE_W + 1) ? $clog2(STRIDE_W) + 1 : $clog2(LINE_W + 1) + 1;

  function automatic logic [SH_W-1:0] low_bit(input logic [STRIDE_W+LINE_W:0] v);
    logic [SH_W-1:0] pos;
    pos = '0;
    for (int i = STRIDE_W + LINE_W; i >= 0; i--)
      if (v[i]) pos = SH_W'(i);
    return pos;
  endfunction

  logic [SH_W-1:0]   s_sh, p_sh, v_sh;
  logic [ADDR_W-1:0] placed, shifted, block, ofs_full;
  logic [LINE_W-1:0] ofs;

  assign s_sh     = low_bit({{(LINE_W+1){1'b0}}, stride});
  assign p_sh     = low_bit({{STRIDE_W{1'b0}}, psize});
  assign v_sh     = low_bit({{STRIDE_W{1'b0}}, vsize});
  assign placed   = addr + mask;
  assign shifted  = placed >> s_sh;
  assign block    = shifted >> WORD_W;
  assign ofs_full = block & ((ADDR_W'(1) << p_sh) - ADDR_W'(1));
  assign ofs      = ofs_full[LINE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_line     <= '0;
      out_word     <= '0;
      out_vline    <= '0;
      out_tag      <= '0;
      out_mem_addr <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_line     <= start + ofs;
        out_word     <= shifted[WORD_W-1:0];
        out_vline    <= ofs >> v_sh;
        out_tag      <= block >> p_sh;
        out_mem_addr <= addr;
      end
    end
  end

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r7_mem_addr_raw: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_mem_addr == $past(addr));
  a_r4_line_in_partition: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ($past(psize) == '0) ? (LINE_W'(out_line - $past(start)) == '0)
                 : ({1'b0, LINE_W'(out_line - $past(start))} < ($past(psize) & (~$past(psize) + 1'b1))));
  a_r5_vline_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_vline <= LINE_W'(out_line - $past(start)));
  a_r8_hold_line: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_line) && $stable(out_word) && $stable(out_tag));

endmodule

// File: tb/part_xlate_test.sv
module part_xlate_test;
  localparam int ADDR_W = 32, LINE_W = 7, WORD_W = 2, STRIDE_W = 8;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [ADDR_W-1:0] addr = 0, mask = 0;
  logic [LINE_W-1:0] start = 0;
  logic [LINE_W:0] psize = 0, vsize = 0;
  logic [STRIDE_W-1:0] stride = 0;
  logic out_valid;
  logic [LINE_W-1:0] out_line, out_vline;
  logic [WORD_W-1:0] out_word;
  logic [ADDR_W-1:0] out_tag, out_mem_addr;

  int vecs = 0, bad = 0;
  bit done = 0;

  part_xlate #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .WORD_W(WORD_W), .STRIDE_W(STRIDE_W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .addr(addr), .start(start),
    .psize(psize), .vsize(vsize), .stride(stride), .mask(mask), .out_valid(out_valid),
    .out_line(out_line), .out_word(out_word), .out_vline(out_vline), .out_tag(out_tag),
    .out_mem_addr(out_mem_addr));

  always #2 clk = ~clk;

  function automatic longint pow_low(input longint v);
    for (int i = 0; i < 40; i++) if (v[i]) return longint'(1) << i;
    return 1;
  endfunction

  task automatic cmp(input string tag, input longint act, input longint exp);
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(input logic [ADDR_W-1:0] a, input logic [LINE_W-1:0] st,
                     input logic [LINE_W:0] ps, input logic [LINE_W:0] vs,
                     input logic [STRIDE_W-1:0] sd, input logic [ADDR_W-1:0] mk,
                     input int xl, input int xw);
    longint pa, sh, blk, p, ofs, eline, ewrd, evl, etag;
    @(negedge clk);
    in_valid = 1; addr = a; start = st; psize = ps; vsize = vs; stride = sd; mask = mk;
    pa   = (longint'(a) + longint'(mk)) % (longint'(1) << ADDR_W);
    sh   = pa / pow_low(longint'(sd));
    ewrd = sh % 4;
    blk  = sh / 4;
    p    = pow_low(longint'(ps));
    ofs  = blk % p;
    eline = (longint'(st) + ofs) % 128;
    evl  = ofs / pow_low(longint'(vs));
    etag = blk / p;
    @(negedge clk);
    vecs++;
    cmp("R1 out_valid", out_valid, 1);
    cmp("R2/R3 out_word", out_word, ewrd);
    cmp("R4 out_line", out_line, eline);
    cmp("R5 out_vline", out_vline, evl);
    cmp("R6 out_tag", out_tag, etag);
    cmp("R7 out_mem_addr", out_mem_addr, a);
    if (xl >= 0) cmp("R4 example line", out_line, xl);
    if (xw >= 0) cmp("R3 example word", out_word, xw);
  endtask

  initial begin
    int ex_line [10] = '{8,8,8,8,9,9,9,9,10,10};
    int mk_line [10] = '{8,8,9,9,9,9,10,10,10,10};
    logic [6:0] hl; logic [1:0] hw; logic [31:0] ht;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    vecs++;
    cmp("R9 reset valid", out_valid, 0);
    cmp("R9 reset line", out_line, 0);
    cmp("R9 reset tag", out_tag, 0);
    rst_n = 1;
    for (int i = 0; i < 10; i++) run(32'(2*i), 7'd8, 8'd4, 8'd2, 8'd2, 32'd0, ex_line[i], i % 4);
    for (int i = 0; i < 10; i++) run(32'(2*i), 7'd8, 8'd4, 8'd2, 8'd2, 32'd4, mk_line[i], (i + 2) % 4);
    run(32'hFFFF_FFFC, 7'd127, 8'd128, 8'd0, 8'd0, 32'd8, -1, -1);   // R2 wrap of sum, R4 line wrap
    run(32'h1234_5678, 7'd3, 8'd0, 8'd0, 8'd128, 32'h0, 3, -1);       // R4 zero size
    run(32'h0000_00F3, 7'd0, 8'd6, 8'd3, 8'd12, 32'h10, -1, -1);      // non power of two fields
    run(32'h8000_0000, 7'd5, 8'd64, 8'd16, 8'd1, 32'hFFFF_FFFF, -1, -1);
    @(negedge clk);
    in_valid = 0;
    @(negedge clk);
    vecs++;
    cmp("R1 idle valid", out_valid, 0);
    hl = out_line; hw = out_word; ht = out_tag;
    addr = 32'hDEAD_BEEF; mask = 32'h55; start = 7'd1; stride = 8'd4;
    repeat (3) @(negedge clk);
    vecs++;
    cmp("R8 hold line", out_line, hl);
    cmp("R8 hold word", out_word, hw);
    cmp("R8 hold tag", out_tag, ht);
    for (int i = 0; i < 400; i++) begin
      logic [LINE_W:0] ps, vs;
      ps = 8'(1) << ($urandom % 8);
      vs = 8'(1) << ($urandom % 8);
      if ($urandom % 8 == 0) ps = 8'($urandom);
      if ($urandom % 8 == 0) vs = 8'($urandom);
      run($urandom, 7'($urandom), ps, vs, ($urandom % 6 == 0) ? 8'($urandom) : 8'(1) << ($urandom % 8),
          ($urandom % 4 == 0) ? 32'd0 : $urandom, -1, -1);
    end
    @(negedge clk);
    in_valid = 0;
    rst_n = 0;
    @(negedge clk);
    vecs++;
    cmp("R9 reset after run", out_valid, 0);
    cmp("R9 reset line after run", out_line, 0);
    cmp("R9 reset addr after run", out_mem_addr, 0);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule